// File: doc/BRIEF.md
# Five-Stage Pipeline Control Sequencer

This block is the control spine of an in-order five-stage pipeline. Each clock it may accept one already-decoded instruction, given as a class code, a valid flag and a destination register number. It carries that instruction through fetch, decode, execute, memory and writeback. Every clock it raises the enables of the shared functional units for whatever sits in each stage.

Every class follows the same five-slot timeline. A class that has no work in a stage simply idles there, so each shared unit is always claimed at one fixed stage position. Because of this, the register-file write port is only ever driven from the last stage. The block also reports the occupancy phase of the pipeline and keeps a running count of retired instructions. The datapath, the memories, hazard handling and branch redirection live outside it.

Top module: `pipe_ctrl_seq`

## Requirements
- R1: Class codes are 2'b00 register-type ALU op, 2'b01 load, 2'b10 store, 2'b11 branch. An instruction accepted with `in_valid` high at a rising edge holds the fetch stage during the next cycle and then advances one stage per cycle, so it holds writeback four cycles after fetch. `en_imem_rd` is high exactly when fetch holds a valid instruction.
- R2: `en_rf_rd` is high exactly when decode holds a valid instruction, and `en_alu` is high exactly when execute holds one, whatever its class.
- R3: `en_dmem_rd` is high only when the memory stage holds a valid load. `en_dmem_wr` is high only when it holds a valid store. Register-type and branch instructions leave both low, and the two are never high together.
- R4: `en_rf_wr` is high only when writeback holds a valid load or register-type instruction, and `rf_wr_addr` then carries its destination (zero otherwise). Stores and branches never write, and no write is raised for an instruction in the memory stage.
- R5: A load or register-type instruction whose destination is register 0 keeps `en_rf_wr` low and `rf_wr_addr` zero in its writeback cycle.
- R6: An input cycle with `in_valid` low travels through the stages as a bubble, and every unit enable belonging to the stage it occupies stays low.
- R7: `pipe_state` is 2'b00 empty when no stage is valid, 2'b10 full when all five are, 2'b01 filling when fetch is valid but some stage is not, and 2'b11 draining when some stage is valid but fetch is not. Five instructions fed back to back give filling in cycles 1 to 4, full in cycle 5, draining in cycles 6 to 9 and empty after that.
- R8: `retire` is high during each cycle in which writeback holds a valid instruction of any class, and `retire_count` is one higher after that cycle's closing edge.
- R9: A synchronous active-high `rst` empties every stage and clears `retire_count`, leaving all enables and `retire` low and `pipe_state` empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_class | input | 2 | Class code of the offered instruction |
| in_rd | input | RD_W (5) | Destination register of the offered instruction |
| en_imem_rd | output | 1 | Instruction-memory read enable (fetch) |
| en_rf_rd | output | 1 | Register-file read enable (decode) |
| en_alu | output | 1 | ALU enable (execute) |
| en_dmem_rd | output | 1 | Data-memory read enable (memory stage, load) |
| en_dmem_wr | output | 1 | Data-memory write enable (memory stage, store) |
| en_rf_wr | output | 1 | Register-file write enable (writeback) |
| rf_wr_addr | output | RD_W (5) | Register written when `en_rf_wr` is high |
| pipe_state | output | 2 | Occupancy phase: empty, filling, full, draining |
| retire | output | 1 | Writeback holds a valid instruction this cycle |
| retire_count | output | CNT_W (16) | Running count of retired instructions |

## Verification
A run of five back-to-back loads shows the fill, full and drain phases cycle by cycle. It also separates a memory read in stage four from a register write in stage five. Runs of each class with destination zero and nonzero separate the classes that write back from those that idle there, and expose any leak of a zero-register write. Bubbles spaced between instructions show whether an empty slot drives a unit. Long random mixes of classes, destinations and valid gaps, together with a reset in mid-flight, test the stage alignment of every enable and the retire counter.

// File: rtl/pipe_ctrl_pkg.sv
package pipe_ctrl_pkg;

    localparam int unsigned NUM_STAGES = 5;

    localparam int unsigned S_FETCH = 0;
    localparam int unsigned S_DEC   = 1;
    localparam int unsigned S_EXE   = 2;
    localparam int unsigned S_MEM   = 3;
    localparam int unsigned S_WB    = 4;

    typedef enum logic [1:0] {
        CLS_ALU    = 2'b00,
        CLS_LOAD   = 2'b01,
        CLS_STORE  = 2'b10,
        CLS_BRANCH = 2'b11
    } instr_cls_e;

    typedef enum logic [1:0] {
        PS_EMPTY    = 2'b00,
        PS_FILLING  = 2'b01,
        PS_FULL     = 2'b10,
        PS_DRAINING = 2'b11
    } pipe_state_e;

    // Whether a class does real work in a given stage position.
    function automatic logic stage_used(logic [1:0] cls, int unsigned stg);
        case (stg)
            S_MEM:   return (cls == CLS_LOAD) || (cls == CLS_STORE);
            S_WB:    return (cls == CLS_LOAD) || (cls == CLS_ALU);
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/pipe_slot_shift.sv
module pipe_slot_shift
    import pipe_ctrl_pkg::*;
#(
    parameter int unsigned RD_W = 5
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             in_valid,
    input  logic [1:0]                       in_class,
    input  logic [RD_W-1:0]                  in_rd,
    output logic [NUM_STAGES-1:0]            slot_v,
    output logic [NUM_STAGES-1:0][1:0]       slot_cls,
    output logic [NUM_STAGES-1:0][RD_W-1:0]  slot_rd
);

    typedef struct packed {
        logic [NUM_STAGES-1:0]            v;
        logic [NUM_STAGES-1:0][1:0]       cls;
        logic [NUM_STAGES-1:0][RD_W-1:0]  rd;
    } slots_t;

    slots_t slots_d, slots_q;

    always_comb begin
        slots_d = slots_q;
        // Entry slot: a bubble carries zeroed fields.
        slots_d.v[S_FETCH]   = in_valid;
        slots_d.cls[S_FETCH] = in_valid ? in_class : 2'b00;
        slots_d.rd[S_FETCH]  = in_valid ? in_rd : '0;
        for (int unsigned k = 1; k < NUM_STAGES; k++) begin
            slots_d.v[k]   = slots_q.v[k-1];
            slots_d.cls[k] = slots_q.cls[k-1];
            slots_d.rd[k]  = slots_q.rd[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= '0;
        end else begin
            slots_q <= slots_d;
        end
    end

    assign slot_v   = slots_q.v;
    assign slot_cls = slots_q.cls;
    assign slot_rd  = slots_q.rd;

endmodule

// File: rtl/unit_enable_decode.sv
module unit_enable_decode
    import pipe_ctrl_pkg::*;
#(
    parameter int unsigned RD_W = 5
) (
    input  logic [NUM_STAGES-1:0]            slot_v,
    input  logic [NUM_STAGES-1:0][1:0]       slot_cls,
    input  logic [NUM_STAGES-1:0][RD_W-1:0]  slot_rd,
    output logic                             en_imem_rd,
    output logic                             en_rf_rd,
    output logic                             en_alu,
    output logic                             en_dmem_rd,
    output logic                             en_dmem_wr,
    output logic                             en_rf_wr,
    output logic [RD_W-1:0]                  rf_wr_addr
);

    logic [NUM_STAGES-1:0] busy;

    // A stage claims its unit only for a valid occupant that needs it.
    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        assign busy[k] = slot_v[k] & stage_used(slot_cls[k], k);
    end

    logic wb_nonzero;

    always_comb begin
        wb_nonzero = |slot_rd[S_WB];
        en_imem_rd = busy[S_FETCH];
        en_rf_rd   = busy[S_DEC];
        en_alu     = busy[S_EXE];
        en_dmem_rd = busy[S_MEM] && (slot_cls[S_MEM] == CLS_LOAD);
        en_dmem_wr = busy[S_MEM] && (slot_cls[S_MEM] == CLS_STORE);
        en_rf_wr   = busy[S_WB] && wb_nonzero;
        rf_wr_addr = en_rf_wr ? slot_rd[S_WB] : '0;
    end

endmodule

// File: rtl/pipe_status_track.sv
module pipe_status_track
    import pipe_ctrl_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_STAGES-1:0] slot_v,
    output logic [1:0]            pipe_state,
    output logic                  retire,
    output logic [CNT_W-1:0]      retire_count
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } trk_t;

    trk_t trk_d, trk_q;
    pipe_state_e state_c;

    always_comb begin
        trk_d     = trk_q;
        trk_d.cnt = trk_q.cnt + CNT_W'(slot_v[S_WB]);

        if (slot_v == '0) begin
            state_c = PS_EMPTY;
        end else if (&slot_v) begin
            state_c = PS_FULL;
        end else if (slot_v[S_FETCH]) begin
            state_c = PS_FILLING;
        end else begin
            state_c = PS_DRAINING;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign pipe_state   = state_c;
    assign retire       = slot_v[S_WB];
    assign retire_count = trk_q.cnt;

endmodule

// File: rtl/pipe_ctrl_seq.sv
module pipe_ctrl_seq
    import pipe_ctrl_pkg::*;
#(
    parameter int unsigned RD_W  = 5,
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_class,
    input  logic [RD_W-1:0]   in_rd,
    output logic              en_imem_rd,
    output logic              en_rf_rd,
    output logic              en_alu,
    output logic              en_dmem_rd,
    output logic              en_dmem_wr,
    output logic              en_rf_wr,
    output logic [RD_W-1:0]   rf_wr_addr,
    output logic [1:0]        pipe_state,
    output logic              retire,
    output logic [CNT_W-1:0]  retire_count
);

    logic [NUM_STAGES-1:0]            slot_v;
    logic [NUM_STAGES-1:0][1:0]       slot_cls;
    logic [NUM_STAGES-1:0][RD_W-1:0]  slot_rd;

    pipe_slot_shift #(.RD_W(RD_W)) u_slots (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_class (in_class),
        .in_rd    (in_rd),
        .slot_v   (slot_v),
        .slot_cls (slot_cls),
        .slot_rd  (slot_rd)
    );

    unit_enable_decode #(.RD_W(RD_W)) u_dec (
        .slot_v     (slot_v),
        .slot_cls   (slot_cls),
        .slot_rd    (slot_rd),
        .en_imem_rd (en_imem_rd),
        .en_rf_rd   (en_rf_rd),
        .en_alu     (en_alu),
        .en_dmem_rd (en_dmem_rd),
        .en_dmem_wr (en_dmem_wr),
        .en_rf_wr   (en_rf_wr),
        .rf_wr_addr (rf_wr_addr)
    );

    pipe_status_track #(.CNT_W(CNT_W)) u_trk (
        .clk          (clk),
        .rst          (rst),
        .slot_v       (slot_v),
        .pipe_state   (pipe_state),
        .retire       (retire),
        .retire_count (retire_count)
    );

endmodule

// File: rtl/pipe_ctrl_chk.sv
module pipe_ctrl_chk
    import pipe_ctrl_pkg::*;
#(
    parameter int unsigned RD_W  = 5,
    parameter int unsigned CNT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        in_class,
    input logic [RD_W-1:0]   in_rd,
    input logic              en_imem_rd,
    input logic              en_rf_rd,
    input logic              en_alu,
    input logic              en_dmem_rd,
    input logic              en_dmem_wr,
    input logic              en_rf_wr,
    input logic [RD_W-1:0]   rf_wr_addr,
    input logic [1:0]        pipe_state,
    input logic              retire,
    input logic [CNT_W-1:0]  retire_count
);

    p_fetch_follow_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> en_imem_rd);

    p_fetch_bubble_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !en_imem_rd);

    p_dmem_rd_load_r3: assert property (@(posedge clk) disable iff (rst)
        en_dmem_rd |-> ($past(in_valid, 4) && $past(in_class, 4) == CLS_LOAD));

    p_dmem_wr_store_r3: assert property (@(posedge clk) disable iff (rst)
        en_dmem_wr |-> ($past(in_valid, 4) && $past(in_class, 4) == CLS_STORE));

    p_dmem_excl_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({en_dmem_rd, en_dmem_wr}));

    p_rfwr_stage5_r4: assert property (@(posedge clk) disable iff (rst)
        en_rf_wr |-> ($past(in_valid, 5)
                      && ($past(in_class, 5) == CLS_ALU || $past(in_class, 5) == CLS_LOAD)
                      && rf_wr_addr == $past(in_rd, 5)));

    p_rfwr_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        en_rf_wr |-> (rf_wr_addr != '0));

    p_full_units_r7: assert property (@(posedge clk) disable iff (rst)
        (pipe_state == PS_FULL) |-> (en_imem_rd && en_rf_rd && en_alu && retire));

    p_retire_count_r8: assert property (@(posedge clk) disable iff (rst)
        retire |=> (retire_count == CNT_W'($past(retire_count) + 1'b1)));

    p_hold_count_r8: assert property (@(posedge clk) disable iff (rst)
        !retire |=> $stable(retire_count));

endmodule

bind pipe_ctrl_seq pipe_ctrl_chk #(.RD_W(RD_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_class     (in_class),
    .in_rd        (in_rd),
    .en_imem_rd   (en_imem_rd),
    .en_rf_rd     (en_rf_rd),
    .en_alu       (en_alu),
    .en_dmem_rd   (en_dmem_rd),
    .en_dmem_wr   (en_dmem_wr),
    .en_rf_wr     (en_rf_wr),
    .rf_wr_addr   (rf_wr_addr),
    .pipe_state   (pipe_state),
    .retire       (retire),
    .retire_count (retire_count)
);

// File: tb/sim_pipe_ctrl_seq.sv
module sim_pipe_ctrl_seq;

    localparam int RD_W  = 5;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [1:0]       in_class = 2'b00;
    logic [RD_W-1:0]  in_rd = '0;
    logic             en_imem_rd, en_rf_rd, en_alu, en_dmem_rd, en_dmem_wr, en_rf_wr;
    logic [RD_W-1:0]  rf_wr_addr;
    logic [1:0]       pipe_state;
    logic             retire;
    logic [CNT_W-1:0] retire_count;

    pipe_ctrl_seq #(.RD_W(RD_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class), .in_rd(in_rd),
        .en_imem_rd(en_imem_rd), .en_rf_rd(en_rf_rd), .en_alu(en_alu),
        .en_dmem_rd(en_dmem_rd), .en_dmem_wr(en_dmem_wr), .en_rf_wr(en_rf_wr),
        .rf_wr_addr(rf_wr_addr), .pipe_state(pipe_state), .retire(retire),
        .retire_count(retire_count)
    );

    always #4 clk = ~clk;   // 125 MHz

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    // Bench model of the five stages, built from the requirements.
    bit         mv  [5];
    logic [1:0] mc  [5];
    logic [4:0] mrd [5];
    int         mcnt = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit writes_back(input logic [1:0] c);
        return (c == 2'b00) || (c == 2'b01);
    endfunction

    function automatic logic [1:0] exp_state();
        int n = 0;
        for (int k = 0; k < 5; k++) n += mv[k];
        if (n == 0) return 2'b00;
        if (n == 5) return 2'b10;
        if (mv[0])  return 2'b01;
        return 2'b11;
    endfunction

    task automatic check_all();
        bit wr;
        string t;
        chk(mv[0] ? "R1" : "R6", "en_imem_rd", 32'(en_imem_rd), 32'(mv[0]));
        chk(mv[1] ? "R2" : "R6", "en_rf_rd",   32'(en_rf_rd),   32'(mv[1]));
        chk(mv[2] ? "R2" : "R6", "en_alu",     32'(en_alu),     32'(mv[2]));
        chk(mv[3] ? "R3" : "R6", "en_dmem_rd", 32'(en_dmem_rd), 32'(mv[3] && mc[3] == 2'b01));
        chk(mv[3] ? "R3" : "R6", "en_dmem_wr", 32'(en_dmem_wr), 32'(mv[3] && mc[3] == 2'b10));
        wr = mv[4] && writes_back(mc[4]) && (mrd[4] != 0);
        t  = (mv[4] && writes_back(mc[4]) && mrd[4] == 0) ? "R5" : (mv[4] ? "R4" : "R6");
        chk(t, "en_rf_wr",   32'(en_rf_wr),   32'(wr));
        chk(t, "rf_wr_addr", 32'(rf_wr_addr), wr ? 32'(mrd[4]) : 32'd0);
        chk("R7", "pipe_state",   32'(pipe_state),   32'(exp_state()));
        chk("R8", "retire",       32'(retire),       32'(mv[4]));
        chk("R8", "retire_count", 32'(retire_count), 32'(mcnt % (1 << CNT_W)));
    endtask

    task automatic step(input bit v, input logic [1:0] c, input logic [4:0] rd, input bit r);
        @(negedge clk);
        check_all();
        in_valid = v; in_class = c; in_rd = rd; rst = r;
        @(posedge clk);
        #1;
        if (r) begin
            for (int k = 0; k < 5; k++) begin mv[k] = 0; mc[k] = 0; mrd[k] = 0; end
            mcnt = 0;
        end else begin
            if (mv[4]) mcnt++;
            for (int k = 4; k > 0; k--) begin
                mv[k] = mv[k-1]; mc[k] = mc[k-1]; mrd[k] = mrd[k-1];
            end
            mv[0] = v; mc[0] = v ? c : 2'b00; mrd[0] = v ? rd : 5'd0;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [1:0] exp_ph [10];
        void'($urandom(32'h00c0ffee));
        for (int k = 0; k < 5; k++) begin mv[k] = 0; mc[k] = 0; mrd[k] = 0; end

        // R9: reset state
        repeat (3) step(0, 0, 0, 1);
        step(1, 2'b01, 5'd9, 1);   // offered during reset: must not enter
        chk("R9", "retire_count after reset", 32'(retire_count), 0);
        chk("R9", "pipe_state after reset",   32'(pipe_state),   0);
        chk("R9", "en_imem_rd after reset",   32'(en_imem_rd),   0);

        // R7: five back-to-back loads, explicit phase sequence
        exp_ph = '{2'b01, 2'b01, 2'b01, 2'b01, 2'b10, 2'b11, 2'b11, 2'b11, 2'b11, 2'b00};
        for (int i = 0; i < 10; i++) begin
            step(i < 5, 2'b01, 5'(i + 1), 0);
            chk("R7", $sformatf("phase cycle %0d", i + 1), 32'(pipe_state), 32'(exp_ph[i]));
        end
        chk("R8", "count after five loads", 32'(retire_count), 5);

        // R3/R4/R5: each class with destination zero and nonzero
        for (int c = 0; c < 4; c++) begin
            step(1, 2'(c), 5'd0, 0);
            step(1, 2'(c), 5'd17, 0);
        end
        repeat (6) step(0, 0, 0, 0);

        // R6: bubbles spaced between instructions
        for (int i = 0; i < 12; i++) step(i % 3 == 0, 2'(i % 4), 5'(i + 3), 0);
        repeat (6) step(0, 0, 0, 0);

        // Random mix with valid gaps
        for (int i = 0; i < 400; i++)
            step(($urandom % 10) < 7, 2'($urandom), 5'($urandom), 0);

        // R9: reset in mid-flight
        for (int i = 0; i < 4; i++) step(1, 2'b00, 5'd5, 0);
        step(0, 0, 0, 1);
        chk("R9", "retire_count after mid reset", 32'(retire_count), 0);
        chk("R9", "pipe_state after mid reset",   32'(pipe_state),   0);
        chk("R9", "en_rf_wr after mid reset",     32'(en_rf_wr),     0);

        for (int i = 0; i < 200; i++)
            step(($urandom % 10) < 8, 2'($urandom), 5'($urandom), 0);
        repeat (7) step(0, 0, 0, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule